// File: doc/BRIEF.md
# Baseband Hang Pattern Classifier

This block decides whether the baseband processor has stalled and, if so, which known kind of stall it is, from one 32-bit observation word exported by the baseband. A single start pulse launches a check. The block captures the word at the start edge. It then re-samples the live word on 50 further clock edges and requires every sample to equal the captured copy. A word that moves during that run means the baseband is alive, and the baseband result is "no hang".

A word that stays put is tested against four masked patterns, in a fixed order, and the first match names the hang. A steady word that fits none of the four is reported as an unknown hang. The block also sequences a separate DMA-engine hang detector. That detector is launched only when DMA checking was enabled at start and the baseband check found nothing, because a stalled baseband already implies a stalled DMA path. Its result is captured into a field of its own. A one-cycle done strobe closes every check.

Top module: `bb_hang_classifier`

## Requirements
- R1: After reset, `done_o`, `dma_req_o`, `hang_code_o` and `dma_code_o` are all zero.
- R2: With baseband checking enabled, the word captured at the start edge must equal `obs_word_i` on each of the next 50 clock edges. A difference on any of them, including the 50th, ends the watch with `hang_code_o` = 0.
- R3: A steady word with (word & 0x7E000B00) == 0x1E000000 gives `hang_code_o` = 1 (radar detection hang).
- R4: A steady word with (word & 0x7E000B00) == 0x52000B00 gives `hang_code_o` = 2 (interframe spacing hang).
- R5: A steady word with (word & 0x7E000B00) == 0x18000B00, or with (word & 0x7E7FFFEF) == 0x00702400, gives `hang_code_o` = 3 (receive clear hang). Bits outside the mask have no effect on the code.
- R6: The four patterns are tried in the order R3, R4, R5 first pair, R5 second pair, and the first match wins. A steady word matching none gives `hang_code_o` = 4 (unknown).
- R7: On the edge that accepts a start, `hang_code_o` and `dma_code_o` both clear to zero.
- R8: `dma_req_o` pulses for one cycle only when DMA checking was enabled at start and the baseband result is 0. When a baseband hang is found, no request is issued and `dma_code_o` stays 0.
- R9: With baseband checking disabled, `dma_req_o` is raised on the start edge itself, or `done_o` is raised on that edge when DMA checking is also disabled. `dma_code_o` takes `dma_code_i` from the edge on which `dma_done_i` is seen high.
- R10: `done_o` is a single-cycle pulse. It rises 50 edges after the start edge for a steady word. It rises on the mismatch edge when no DMA check follows. Otherwise it rises on the edge that sees `dma_done_i`.
- R11: A start pulse that arrives while a check is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a check when the block is idle |
| bb_chk_en_i | input | 1 | Enables the baseband watch for this check |
| dma_chk_en_i | input | 1 | Allows the DMA detector to run for this check |
| obs_word_i | input | 32 | Live baseband observation word |
| dma_req_o | output | 1 | One-cycle launch pulse to the DMA hang detector |
| dma_done_i | input | 1 | DMA detector has finished |
| dma_code_i | input | 2 | DMA detector result, valid with `dma_done_i` |
| hang_code_o | output | 3 | Baseband result: 0 none, 1 radar, 2 interframe spacing, 3 receive clear, 4 unknown |
| dma_code_o | output | 2 | Captured DMA detector result |
| done_o | output | 1 | One-cycle pulse when the check is complete |

## Verification
The edge that accepts a start is counted as cycle 0. A steady word produces done and its code at cycle 50. A word changed before edge k produces done at cycle k when no DMA check follows. When a DMA check does follow, the request is seen at that same cycle, and done lands one cycle after the cycle in which the bench raises `dma_done_i`. The bench samples on falling edges and records the cycle index of each done and request pulse, so every pulse is compared with its computed cycle rather than just waited for. It also confirms the clear at cycle 0, that done is seen exactly once, and that no request appears when a baseband hang was found.

// File: rtl/bbh_pkg.sv
package bbh_pkg;

  localparam int unsigned OBS_W    = 32;
  localparam int unsigned NUM_SIGS = 4;
  localparam int unsigned CODE_W   = 3;

  typedef enum logic [CODE_W-1:0] {
    HC_NONE    = 3'd0,
    HC_RADAR   = 3'd1,
    HC_IFS     = 3'd2,
    HC_RXCLR   = 3'd3,
    HC_UNKNOWN = 3'd4
  } hang_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WATCH,
    ST_DMA
  } ctl_state_e;

  // Ordered signature table: lower index has higher priority.
  function automatic logic [OBS_W-1:0] sig_mask(input int unsigned idx);
    case (idx)
      0, 1, 2: sig_mask = 32'h7E00_0B00;
      default: sig_mask = 32'h7E7F_FFEF;
    endcase
  endfunction

  function automatic logic [OBS_W-1:0] sig_value(input int unsigned idx);
    case (idx)
      0:       sig_value = 32'h1E00_0000;
      1:       sig_value = 32'h5200_0B00;
      2:       sig_value = 32'h1800_0B00;
      default: sig_value = 32'h0070_2400;
    endcase
  endfunction

  function automatic hang_code_e sig_code(input int unsigned idx);
    case (idx)
      0:       sig_code = HC_RADAR;
      1:       sig_code = HC_IFS;
      default: sig_code = HC_RXCLR;
    endcase
  endfunction

endpackage

// File: rtl/bbh_word_monitor.sv
module bbh_word_monitor #(
  parameter int unsigned W     = 32,
  parameter int unsigned N_RS  = 50
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic         active_o,
  output logic         changed_o,
  output logic         stable_o,
  output logic [W-1:0] held_o
);
  localparam int unsigned CW = $clog2(N_RS + 1);
  localparam logic [CW-1:0] LAST = CW'(N_RS - 1);

  logic [CW-1:0] run_cnt;
  logic          active_q;
  logic [W-1:0]  held_q;

  assign active_o  = active_q;
  assign held_o    = held_q;
  assign changed_o = active_q && (word_i != held_q);
  assign stable_o  = active_q && (word_i == held_q) && (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      run_cnt  <= '0;
      held_q   <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      run_cnt  <= '0;
      held_q   <= word_i;
    end else if (active_q) begin
      if (changed_o || stable_o) begin
        active_q <= 1'b0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R2: the resample count never runs past the required window
  p_run_bound_r2: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (run_cnt <= LAST));

  // R2: the captured word does not move while watching
  p_held_steady_r2: assert property (@(posedge clk) disable iff (rst)
    (active_q && !load_i) |=> $stable(held_q));

endmodule

// File: rtl/bbh_sig_match.sv
module bbh_sig_match
  import bbh_pkg::*;
#(
  parameter int unsigned W = OBS_W,
  parameter int unsigned N = NUM_SIGS
) (
  input  logic [W-1:0] word_i,
  output hang_code_e   code_o
);
  logic [N-1:0] hit;

  for (genvar g = 0; g < int'(N); g++) begin : g_sig
    assign hit[g] = ((word_i & W'(sig_mask(g))) == W'(sig_value(g)));
  end

  // Walk from the lowest priority up so the first table entry wins.
  always_comb begin
    code_o = HC_UNKNOWN;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (hit[i]) code_o = sig_code(i);
    end
  end

  // R6: any hit must yield a named code, never unknown
  always_comb begin
    if (|hit) p_hit_named_r6: assert (code_o != HC_UNKNOWN);
  end

endmodule

// File: rtl/bb_hang_classifier.sv
module bb_hang_classifier
  import bbh_pkg::*;
#(
  parameter int unsigned NUM_RESAMPLES = 50,
  parameter int unsigned DMA_CODE_W    = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic                  bb_chk_en_i,
  input  logic                  dma_chk_en_i,
  input  logic [OBS_W-1:0]      obs_word_i,
  output logic                  dma_req_o,
  input  logic                  dma_done_i,
  input  logic [DMA_CODE_W-1:0] dma_code_i,
  output logic [CODE_W-1:0]     hang_code_o,
  output logic [DMA_CODE_W-1:0] dma_code_o,
  output logic                  done_o
);
  ctl_state_e       state;
  logic             dma_allowed;
  logic             load;
  logic             mon_active;
  logic             mon_changed;
  logic             mon_stable;
  logic [OBS_W-1:0] held_word;
  hang_code_e       match_code;

  assign load = (state == ST_IDLE) && start_i && bb_chk_en_i;

  bbh_word_monitor #(
    .W    (OBS_W),
    .N_RS (NUM_RESAMPLES)
  ) u_monitor (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .word_i    (obs_word_i),
    .active_o  (mon_active),
    .changed_o (mon_changed),
    .stable_o  (mon_stable),
    .held_o    (held_word)
  );

  bbh_sig_match #(
    .W (OBS_W),
    .N (NUM_SIGS)
  ) u_match (
    .word_i (held_word),
    .code_o (match_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      dma_allowed <= 1'b0;
      dma_req_o   <= 1'b0;
      done_o      <= 1'b0;
      hang_code_o <= HC_NONE;
      dma_code_o  <= '0;
    end else begin
      done_o    <= 1'b0;
      dma_req_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            hang_code_o <= HC_NONE;
            dma_code_o  <= '0;
            dma_allowed <= dma_chk_en_i;
            if (bb_chk_en_i) begin
              state <= ST_WATCH;
            end else if (dma_chk_en_i) begin
              dma_req_o <= 1'b1;
              state     <= ST_DMA;
            end else begin
              done_o <= 1'b1;
            end
          end
        end
        ST_WATCH: begin
          if (mon_stable) begin
            hang_code_o <= match_code;
            done_o      <= 1'b1;
            state       <= ST_IDLE;
          end else if (mon_changed) begin
            if (dma_allowed) begin
              dma_req_o <= 1'b1;
              state     <= ST_DMA;
            end else begin
              done_o <= 1'b1;
              state  <= ST_IDLE;
            end
          end
        end
        ST_DMA: begin
          if (dma_done_i) begin
            dma_code_o <= dma_code_i;
            done_o     <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: done is a single-cycle strobe
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: the DMA launch is a single-cycle pulse
  p_dma_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    dma_req_o |=> !dma_req_o);

  // R8: a DMA launch never follows a found baseband hang
  p_dma_only_clean_r8: assert property (@(posedge clk) disable iff (rst)
    dma_req_o |-> (hang_code_o == HC_NONE));

  // R7: accepting a start clears both result fields
  p_clear_on_start_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start_i) |=> (hang_code_o == HC_NONE && dma_code_o == '0));

  // R6: the reported code stays within the defined set
  p_code_legal_r6: assert property (@(posedge clk) disable iff (rst)
    hang_code_o <= HC_UNKNOWN);

  // R11: a start during an unfinished watch does not disturb it
  p_busy_ignores_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WATCH && start_i && !mon_changed && !mon_stable) |=> mon_active);

endmodule

// File: tb/bb_hang_classifier_tb_top.sv
module bb_hang_classifier_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic        bb_chk_en_i;
  logic        dma_chk_en_i;
  logic [31:0] obs_word_i;
  logic        dma_req_o;
  logic        dma_done_i;
  logic [1:0]  dma_code_i;
  logic [2:0]  hang_code_o;
  logic [1:0]  dma_code_o;
  logic        done_o;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  bb_hang_classifier dut_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .bb_chk_en_i  (bb_chk_en_i),
    .dma_chk_en_i (dma_chk_en_i),
    .obs_word_i   (obs_word_i),
    .dma_req_o    (dma_req_o),
    .dma_done_i   (dma_done_i),
    .dma_code_i   (dma_code_i),
    .hang_code_o  (hang_code_o),
    .dma_code_o   (dma_code_o),
    .done_o       (done_o)
  );

  function automatic int ref_code(input logic [31:0] w);
    if ((w & 32'h7E00_0B00) == 32'h1E00_0000) return 1;
    if ((w & 32'h7E00_0B00) == 32'h5200_0B00) return 2;
    if ((w & 32'h7E00_0B00) == 32'h1800_0B00) return 3;
    if ((w & 32'h7E7F_FFEF) == 32'h0070_2400) return 3;
    return 4;
  endfunction

  function automatic logic [31:0] make_word(input int kind, input logic [31:0] r);
    case (kind)
      0: return 32'h1E00_0000 | (r & ~32'h7E00_0B00);
      1: return 32'h5200_0B00 | (r & ~32'h7E00_0B00);
      2: return 32'h1800_0B00 | (r & ~32'h7E00_0B00);
      3: return 32'h0070_2400 | (r & ~32'h7E7F_FFEF);
      default: return r;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input bit bb, input bit dma, input logic [31:0] w,
                          input int flip, input int lat, input logic [1:0] dcode,
                          input bit poke);
    int exp_done, exp_code, exp_dma, exp_req;
    int done_cnt, done_at, req_cnt, req_at, got_code, got_dma;
    logic [31:0] fmask;
    fmask = 32'h1 << ($urandom % 32);
    exp_req = 0; exp_code = 0; exp_dma = 0;
    if (bb) begin
      if (flip == 0) begin
        exp_done = 50; exp_code = ref_code(w);
      end else if (dma) begin
        exp_done = flip + lat + 1; exp_req = 1; exp_dma = int'(dcode);
      end else begin
        exp_done = flip;
      end
    end else if (dma) begin
      exp_done = lat + 1; exp_req = 1; exp_dma = int'(dcode);
    end else begin
      exp_done = 0;
    end
    @(negedge clk);
    start_i = 1'b1; bb_chk_en_i = bb; dma_chk_en_i = dma; obs_word_i = w;
    dma_code_i = dcode; dma_done_i = 1'b0;
    done_cnt = 0; done_at = -1; req_cnt = 0; req_at = -1; got_code = -1; got_dma = -1;
    for (int c = 0; c < 70; c++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (c == 0)
        check(hang_code_o == 3'd0 && dma_code_o == 2'd0, "R7", "clear at start",
              {hang_code_o, dma_code_o}, 0);
      if (done_o) begin
        done_cnt++;
        if (done_at < 0) begin
          done_at = c; got_code = int'(hang_code_o); got_dma = int'(dma_code_o);
        end
      end
      if (dma_req_o) begin req_cnt++; req_at = c; end
      dma_done_i = (req_at >= 0) && (c == req_at + lat);
      if (flip > 0 && c == flip - 1) obs_word_i = w ^ fmask;
      if (poke && c == 10) start_i = 1'b1;
    end
    dma_done_i = 1'b0;
    check(done_at == exp_done, "R10", "done cycle", done_at, exp_done);
    check(done_cnt == 1, "R10", "done pulse count", done_cnt, 1);
    if (bb && flip == 0)
      check(got_code == exp_code, exp_code == 1 ? "R3" : exp_code == 2 ? "R4" :
            exp_code == 3 ? "R5" : "R6", "hang code", got_code, exp_code);
    else
      check(got_code == exp_code, "R2", "hang code after change", got_code, exp_code);
    check(req_cnt == exp_req, "R8", "dma request count", req_cnt, exp_req);
    if (exp_req == 1 && !bb)
      check(req_at == 0, "R9", "dma request cycle", req_at, 0);
    check(got_dma == exp_dma, "R9", "dma code", got_dma, exp_dma);
    if (poke)
      check(done_at == 50, "R11", "start while busy ignored", done_at, 50);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; start_i = 1'b0; bb_chk_en_i = 1'b0; dma_chk_en_i = 1'b0;
    obs_word_i = '0; dma_done_i = 1'b0; dma_code_i = '0;
    repeat (3) @(negedge clk);
    check(done_o == 0 && dma_req_o == 0 && hang_code_o == 0 && dma_code_o == 0,
          "R1", "reset outputs", {done_o, dma_req_o, hang_code_o, dma_code_o}, 0);
    @(negedge clk); rst = 1'b0;

    // Directed corners
    run_case(1, 0, make_word(0, $urandom), 0, 0, 2'd0, 0);   // R3
    run_case(1, 1, make_word(1, $urandom), 0, 1, 2'd2, 0);   // R4, R8 no request
    run_case(1, 0, make_word(2, $urandom), 0, 0, 2'd0, 0);   // R5 first pair
    run_case(1, 0, make_word(3, $urandom), 0, 0, 2'd0, 0);   // R5 second pair
    run_case(1, 0, 32'h0000_0000, 0, 0, 2'd0, 0);            // R6 unknown
    run_case(1, 0, make_word(0, $urandom), 1, 0, 2'd0, 0);   // R2 first resample
    run_case(1, 0, make_word(1, $urandom), 50, 0, 2'd0, 0);  // R2 last resample
    run_case(1, 1, make_word(2, $urandom), 7, 0, 2'd3, 0);   // R8 lat 0
    run_case(0, 1, 32'h1234_5678, 0, 2, 2'd1, 0);            // R9
    run_case(0, 0, 32'h0, 0, 0, 2'd0, 0);                    // R9 both off
    run_case(1, 0, make_word(3, $urandom), 0, 0, 2'd0, 1);   // R11

    for (int n = 0; n < 60; n++) begin
      bit bb, dma, poke;
      int kind, flip, lat;
      bb   = ($urandom % 4) != 0;
      dma  = $urandom % 2;
      kind = $urandom % 5;
      flip = (($urandom % 3) == 0) ? 0 : 1 + ($urandom % 50);
      lat  = $urandom % 4;
      poke = bb && flip == 0 && (($urandom % 4) == 0);
      run_case(bb, dma, make_word(kind, $urandom), flip, lat, 2'($urandom % 4), poke);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule